// File: doc/BRIEF.md
# Biphase Line Telegram Decoder

This block decodes one gated video line of sliced, biphase-coded data. It takes one half-bit sample of the sliced data on every clock and a gate that marks the line carrying the telegram. While the gate is high it looks for a start symbol, which deliberately breaks the biphase rule and so fixes the bit alignment. It then reads a six-bit start code and compares it with a parameter. If the code matches, it decodes fifteen 8-bit bytes. From these it keeps byte 5 and bytes 11 to 14 in a shift buffer.

When the last half of byte 14 has been sampled, the block gives exactly one result for the line. It raises a one-cycle valid strobe and updates the 40-bit output word if no biphase violation was seen. Otherwise it raises a one-cycle error strobe and leaves the word unchanged. A start-code mismatch, or a gate that drops before byte 14 ends, abandons the line without any strobe. Data slicing and clock recovery are done upstream.

Top module: `biphase_line_decoder`

## Requirements
- R1: Decoding runs only while `gate_i` is high. A low gate at any time returns the block to hunting and abandons the current line with no strobe.
- R2: After the gate rises, with the line held low before the start symbol, the first two consecutive high samples form the start symbol. The very next sample is the first half of the first start-code bit.
- R3: Every bit takes two samples. High then low means 1, low then high means 0, and two equal halves are a biphase violation. In that case the bit takes the value of its first half.
- R4: The six bits after the start symbol are the start code, with the first received bit as its MSB. A mismatch with `START_CODE` (default 6'b100110) abandons the line with no strobe and leaves `word_o` unchanged.
- R5: After the code come 15 bytes, numbered 1 to 15 in order of arrival. The first received bit of each byte is its MSB.
- R6: On commit, `word_o[39:32]` holds byte 5 and `word_o[31:24]`, `[23:16]`, `[15:8]`, `[7:0]` hold bytes 11, 12, 13 and 14.
- R7: A biphase violation in any start-code bit or in bytes 1 to 14 turns the result into a one-cycle `err_o` strobe instead of `valid_o`, and `word_o` keeps its previous value.
- R8: The strobe is high in the single cycle that follows the clock edge sampling the second half of the last bit of byte 14. The contents of byte 15, including violations, are ignored.
- R9: At most one strobe occurs per gated line. A second telegram inside the same gate is ignored until the gate has gone low.
- R10: During and after reset, `valid_o` and `err_o` are low and `word_o` is all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Half-bit sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gate_i | input | 1 | High during the line that carries the telegram |
| din_i | input | 1 | Sliced data, one half-bit per clock |
| word_o | output | 40 | Last committed kept bytes |
| valid_o | output | 1 | One-cycle strobe for a clean commit |
| err_o | output | 1 | One-cycle strobe for a biphase violation |

## Verification
The hardest situation to reach from the ports is a violation that sits inside the start code. There the code must still match, so that the error survives to byte 14 instead of ending in a silent abort. The stimulus builds that case by repeating the first half of a code bit, which keeps the decoded code value intact. The exact commit cycle is pinned by probing the strobe on the two clock cycles right after byte 14's last sample. A violation placed in byte 15 shows that nothing past byte 14 can spoil a commit.

// File: rtl/biphase_line_decoder.sv
module biphase_line_decoder #(
  parameter logic [5:0] START_CODE = 6'b100110,
  parameter int LAST_BYTE = 14,
  parameter int KEEP_SOLO = 5,
  parameter int KEEP_FROM = 11,
  localparam int W = 8 * (2 + LAST_BYTE - KEEP_FROM)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         gate_i,
  input  logic         din_i,
  output logic [W-1:0] word_o,
  output logic         valid_o,
  output logic         err_o
);

  typedef enum logic [1:0] {HUNT, CODE, DATA, WAIT} state_t;

  state_t       state;
  logic         seen1, phase, half, viol;
  logic [2:0]   cnt;
  logic [3:0]   byten;
  logic [4:0]   code;
  logic [W-1:0] sbuf;

  wire bad  = (half == din_i);
  wire keep = (byten == 4'(KEEP_SOLO)) || (byten >= 4'(KEEP_FROM) && byten <= 4'(LAST_BYTE));
  wire [W-1:0] next_buf = {sbuf[W-2:0], half};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= HUNT;
      seen1   <= 1'b0;
      phase   <= 1'b0;
      half    <= 1'b0;
      viol    <= 1'b0;
      cnt     <= '0;
      byten   <= '0;
      code    <= '0;
      sbuf    <= '0;
      word_o  <= '1;
      valid_o <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      if (!gate_i) begin
        state <= HUNT;
        seen1 <= 1'b0;
      end else begin
        case (state)
          HUNT: begin
            seen1 <= din_i;
            if (seen1 && din_i) begin
              state <= CODE;
              phase <= 1'b0;
              cnt   <= '0;
              viol  <= 1'b0;
              code  <= '0;
            end
          end
          CODE, DATA: begin
            if (!phase) begin
              half  <= din_i;
              phase <= 1'b1;
            end else begin
              phase <= 1'b0;
              viol  <= viol | bad;
              if (state == CODE) begin
                code <= {code[3:0], half};
                if (cnt == 3'd5) begin
                  cnt <= '0;
                  if ({code, half} != START_CODE) state <= WAIT;
                  else begin
                    state <= DATA;
                    byten <= 4'd1;
                  end
                end else cnt <= cnt + 3'd1;
              end else begin
                if (keep) sbuf <= next_buf;
                if (cnt == 3'd7) begin
                  cnt <= '0;
                  if (byten == 4'(LAST_BYTE)) begin
                    state <= WAIT;
                    if (viol | bad) err_o <= 1'b1;
                    else begin
                      valid_o <= 1'b1;
                      word_o  <= next_buf;
                    end
                  end else byten <= byten + 4'd1;
                end else cnt <= cnt + 3'd1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_UNGATED_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_i |=> (state == HUNT) && !valid_o && !err_o); // R1
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_o && err_o)); // R7
  AST_ERR_KEEPS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $stable(word_o)); // R7
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(word_o)); // R4
  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o || err_o) |=> !(valid_o || err_o)); // R9
  AST_PULSE_ENDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o || err_o) |-> (state == WAIT)); // R9

endmodule

// File: tb/biphase_line_decoder_bench.sv
module biphase_line_decoder_bench;
  localparam logic [5:0] SC = 6'b100110;

  logic clk = 1'b0, rst_n = 1'b0, gate_i = 1'b0, din_i = 1'b0;
  logic [39:0] word_o;
  logic valid_o, err_o;
  int errors = 0, checks = 0, nval = 0, nerr = 0;
  bit done = 1'b0;

  biphase_line_decoder u_biphase_line_decoder (
    .clk(clk), .rst_n(rst_n), .gate_i(gate_i), .din_i(din_i),
    .word_o(word_o), .valid_o(valid_o), .err_o(err_o));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (valid_o) nval++;
    if (err_o) nerr++;
  end

  // {code[5:0], violating byte, cut byte, lead}
  localparam logic [15:0] VEC [9] = '{
    {SC, 4'd0, 4'd0, 2'd0},
    {SC, 4'd0, 4'd0, 2'd3},
    {6'b100111, 4'd0, 4'd0, 2'd0},
    {SC, 4'd1, 4'd0, 2'd0},
    {SC, 4'd14, 4'd0, 2'd2},
    {SC, 4'd15, 4'd0, 2'd0},
    {SC, 4'd0, 4'd9, 2'd1},
    {SC, 4'd8, 4'd0, 2'd1},
    {6'b000110, 4'd0, 4'd0, 2'd2}
  };

  function automatic logic [7:0] bv(input int seed, input int b);
    return 8'((seed * 37 + b * 23 + 5) & 255);
  endfunction

  function automatic logic [39:0] wexp(input int seed);
    return {bv(seed, 5), bv(seed, 11), bv(seed, 12), bv(seed, 13), bv(seed, 14)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic half(input logic v);
    @(negedge clk);
    din_i = v;
  endtask

  task automatic send_bit(input logic b, input bit bad);
    half(b);
    half(bad ? b : ~b);
  endtask

  task automatic run_line(input logic [5:0] code, input int vbyte, input int cut, input int lead,
                          input int seed, input int cbad, input bit gated, input bit probe);
    logic [7:0] v;
    @(negedge clk);
    gate_i = gated;
    din_i = 1'b0;
    for (int i = 0; i <= lead; i++) half(1'b0);
    half(1'b1);
    half(1'b1);
    for (int i = 0; i < 6; i++) send_bit(code[5-i], cbad == i);
    for (int b = 1; b <= 15; b++) begin
      if (b == cut) break;
      v = bv(seed, b);
      for (int k = 7; k >= 0; k--) send_bit(v[k], (b == vbyte) && (k == 3));
      if (probe && b == 14) begin
        @(negedge clk);
        chk(valid_o == 1'b1, "R8 strobe right after last sample", 64'(valid_o), 64'd1);
        @(negedge clk);
        chk(valid_o == 1'b0, "R8 strobe lasts one cycle", 64'(valid_o), 64'd0);
      end
    end
    for (int i = 0; i < 4; i++) half(1'b0);
    @(negedge clk);
    gate_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [39:0] last;
    int v0, e0;
    repeat (3) @(negedge clk);
    chk(valid_o == 1'b0, "R10 valid low in reset", 64'(valid_o), 64'd0);
    chk(err_o == 1'b0, "R10 err low in reset", 64'(err_o), 64'd0);
    chk(word_o == '1, "R10 word all ones", 64'(word_o), 64'hFF_FFFF_FFFF);
    rst_n = 1'b1;
    last = '1;

    for (int n = 0; n < 9; n++) begin
      logic [5:0] c;
      int vb, ct, ld;
      bit exp_v, exp_e;
      c  = VEC[n][15:10];
      vb = int'(VEC[n][9:6]);
      ct = int'(VEC[n][5:2]);
      ld = int'(VEC[n][1:0]);
      v0 = nval;
      e0 = nerr;
      run_line(c, vb, ct, ld, n, 99, 1'b1, 1'b0);
      exp_v = (c == SC) && (ct == 0) && (vb == 0 || vb == 15);
      exp_e = (c == SC) && (ct == 0) && (vb >= 1 && vb <= 14);
      if (exp_v) last = wexp(n);
      chk(nval - v0 == int'(exp_v), "R4 R5 R8 valid count", 64'(nval - v0), 64'(exp_v));
      chk(nerr - e0 == int'(exp_e), "R1 R7 err count", 64'(nerr - e0), 64'(exp_e));
      chk(word_o == last, "R2 R3 R6 word", 64'(word_o), 64'(last));
    end

    v0 = nval; e0 = nerr;
    run_line(SC, 0, 0, 0, 20, 99, 1'b0, 1'b0);
    chk(nval == v0 && nerr == e0, "R1 ungated line ignored", 64'(nval - v0), 64'd0);
    chk(word_o == last, "R1 word unchanged", 64'(word_o), 64'(last));

    run_line(SC, 0, 0, 1, 21, 99, 1'b1, 1'b1);
    last = wexp(21);
    chk(word_o == last, "R6 R8 probed word", 64'(word_o), 64'(last));

    e0 = nerr;
    run_line(SC, 0, 0, 0, 22, 2, 1'b1, 1'b0);
    chk(nerr - e0 == 1, "R7 violation in start code", 64'(nerr - e0), 64'd1);
    chk(word_o == last, "R7 word kept on error", 64'(word_o), 64'(last));

    v0 = nval;
    @(negedge clk);
    gate_i = 1'b1;
    din_i = 1'b0;
    half(1'b0); half(1'b1); half(1'b1);
    for (int i = 0; i < 6; i++) send_bit(SC[5-i], 1'b0);
    for (int b = 1; b <= 15; b++)
      for (int k = 7; k >= 0; k--) send_bit(bv(23, b)[k], 1'b0);
    for (int r = 0; r < 2; r++) begin
      repeat (3) half(1'b0);
      half(1'b1); half(1'b1);
      for (int i = 0; i < 6; i++) send_bit(SC[5-i], 1'b0);
      for (int b = 1; b <= 15; b++)
        for (int k = 7; k >= 0; k--) send_bit(bv(24, b)[k], 1'b0);
    end
    @(negedge clk);
    gate_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(nval - v0 == 1, "R9 one strobe per gated line", 64'(nval - v0), 64'd1);
    chk(word_o == wexp(23), "R9 first telegram kept", 64'(word_o), 64'(wexp(23)));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule